// File: doc/BRIEF.md
# Delay-Line Sampling Phase Programmer

This block moves a 16-tap delay line to a new sampling phase with a fixed sequence of control writes. A 4-bit phase number comes in on a valid/ready request port. The block first parks the delay line so that its output selection comes from outside and the output clock is off. It waits until the line reports that its output clock has stopped. It then writes the Gray-coded tap select and turns the output clock back on. Once the line reports that the clock is running again, it hands control back to clock-data recovery.

Both waits poll the line's clock-output feedback only on a one-microsecond tick. Each wait gives up after a bounded number of polls. Each request ends with a one-cycle done pulse or a one-cycle error pulse. The control outputs come out as one 32-bit word with fixed bit positions, so a neighbouring register or the delay line itself can decode the fields directly.

The request port accepts a phase only when `req_valid` and `req_ready` are high in the same cycle. `req_ready` is high only while the block is idle. A requester may hold `req_valid` for as long as it likes: nothing is taken until ready returns, and a request offered while busy has no effect.

Top module: `tap_phase_sequencer`

## Requirements
- R1: After reset, `ctl_word` is all zero, `req_ready` is 1, and `op_done` and `op_error` are 0.
- R2: In the cycle after a request is accepted, `ctl_word` shows CDR enable (bit 17) at 0, output-clock enable (bit 18) at 0, external-select enable (bit 19) at 1 and line enable (bit 16) at 1, and the select field (bits 23:20) still holds its previous value.
- R3: The select field is not rewritten while polls keep seeing `ck_fb` at 1 after the parking step.
- R4: The select field is written with the Gray code of the requested phase. Phases 0 to 15 map to 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8.
- R5: After the select write, bit 18 rises, and the block then waits for `ck_fb` to read 1.
- R6: On success, bit 17 is 1, bit 19 is 0, and bits 16 and 18 are 1 when `op_done` is high. `op_done` lasts exactly one cycle.
- R7: `ck_fb` is sampled only in cycles with `us_tick` high. A wait fails on its POLL_LIMIT-th (default 50) failing poll and no earlier.
- R8: On a timeout, `op_error` pulses for one cycle and `op_done` stays 0. The control word stays as it was when the wait failed, with bit 17 still 0, and the block returns to idle.
- R9: A request offered while `req_ready` is 0 is ignored and does not change the phase that is finally written.
- R10: `req_ready` is high whenever `op_done` or `op_error` is high, and `op_done` and `op_error` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond; paces polling |
| req_valid | input | 1 | Phase request offered |
| req_ready | output | 1 | Block idle; request accepted when valid is also high |
| req_phase | input | 4 | Requested phase, 0 to 15 |
| ck_fb | input | 1 | Delay line reports its output clock enabled |
| ctl_word | output | 32 | Delay-line control: 16 line enable, 17 CDR enable, 18 output-clock enable, 19 external select, 23:20 tap select |
| op_done | output | 1 | One-cycle pulse: phase applied |
| op_error | output | 1 | One-cycle pulse: a wait timed out |

## Verification
The hardest case to reach from the ports is a wait that sits right on its poll limit. The stimulus has to show that the 49th failing poll is harmless and that the 50th fails, and it also has to catch a failure in the second wait after the first wait has already passed. The bench's delay-line model can follow the output-clock enable after a short delay, or it can be pinned high or low. It counts the tick pulses the design sees after acceptance, so the error pulse must land after exactly 50 ticks for a stuck-high line. For a stuck-low line it must land after 51 ticks, one for the passing first wait plus 50. A pinned-high phase that is later released also shows that the select field is held back until the line really stops.

// File: rtl/tap_phase_pkg.sv
package tap_phase_pkg;
  localparam int CTL_W       = 32;
  localparam int POS_LINE_EN = 16;
  localparam int POS_CDR_EN  = 17;
  localparam int POS_CK_EN   = 18;
  localparam int POS_EXT_SEL = 19;
  localparam int POS_SEL_LSB = 20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_OFF,
    ST_WRITE_SEL,
    ST_CK_ON,
    ST_WAIT_ON,
    ST_HANDOVER
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_PARK,
    OP_SEL,
    OP_CK_ON,
    OP_HANDOVER
  } ctl_op_e;
endpackage

// File: rtl/tap_gray_enc.sv
module tap_gray_enc #(
  parameter int W = 4
) (
  input  logic [W-1:0] bin_in,
  output logic [W-1:0] gray_out
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == W - 1) begin : g_top
        assign gray_out[i] = bin_in[i];
      end else begin : g_low
        assign gray_out[i] = bin_in[i] ^ bin_in[i+1];
      end
    end
  endgenerate
endmodule

// File: rtl/tap_poll_window.sv
module tap_poll_window #(
  parameter int POLL_LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  input  logic tick,
  input  logic fb,
  input  logic want,
  output logic hit,
  output logic expire
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] misses;
  logic          sample;

  assign sample = active && tick;
  assign hit    = sample && (fb == want);
  assign expire = sample && !(fb == want) && (misses == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misses <= '0;
    end else if (arm) begin
      misses <= '0;
    end else if (sample && !hit && !expire) begin
      misses <= misses + 1'b1;
    end
  end
endmodule

// File: rtl/tap_ctl_reg.sv
module tap_ctl_reg
  import tap_phase_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_op_e          op,
  input  logic [SEL_W-1:0] sel_code,
  output logic [CTL_W-1:0] word
);
  logic             line_en, cdr_en, ck_en, ext_sel;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_en <= 1'b0;
      cdr_en  <= 1'b0;
      ck_en   <= 1'b0;
      ext_sel <= 1'b0;
      sel_q   <= '0;
    end else begin
      case (op)
        OP_PARK: begin
          cdr_en  <= 1'b0;
          ck_en   <= 1'b0;
          ext_sel <= 1'b1;
          line_en <= 1'b1;
        end
        OP_SEL:      sel_q <= sel_code;
        OP_CK_ON:    ck_en <= 1'b1;
        OP_HANDOVER: begin
          cdr_en  <= 1'b1;
          ext_sel <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    word = '0;
    word[POS_LINE_EN] = line_en;
    word[POS_CDR_EN]  = cdr_en;
    word[POS_CK_EN]   = ck_en;
    word[POS_EXT_SEL] = ext_sel;
    word[POS_SEL_LSB +: SEL_W] = sel_q;
  end
endmodule

// File: rtl/tap_phase_sequencer.sv
module tap_phase_sequencer
  import tap_phase_pkg::*;
#(
  parameter int PHASE_W    = 4,
  parameter int POLL_LIMIT = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               us_tick,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PHASE_W-1:0] req_phase,
  input  logic               ck_fb,
  output logic [CTL_W-1:0]   ctl_word,
  output logic               op_done,
  output logic               op_error
);
  seq_state_e         state_q, state_d;
  ctl_op_e            op;
  logic [PHASE_W-1:0] phase_q, gray_code;
  logic               accept, arm, waiting, want_high, hit, expire;
  logic               done_q, err_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign waiting   = (state_q == ST_WAIT_OFF) || (state_q == ST_WAIT_ON);
  assign want_high = (state_q == ST_WAIT_ON);
  assign arm       = accept || (state_q == ST_CK_ON);

  tap_gray_enc #(.W(PHASE_W)) u_gray (
    .bin_in   (phase_q),
    .gray_out (gray_code)
  );

  tap_poll_window #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm),
    .active (waiting),
    .tick   (us_tick),
    .fb     (ck_fb),
    .want   (want_high),
    .hit    (hit),
    .expire (expire)
  );

  tap_ctl_reg #(.SEL_W(PHASE_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .sel_code (gray_code),
    .word     (ctl_word)
  );

  always_comb begin
    state_d = state_q;
    op      = OP_HOLD;
    case (state_q)
      ST_IDLE: if (accept) begin
        op      = OP_PARK;
        state_d = ST_WAIT_OFF;
      end
      ST_WAIT_OFF: begin
        if (hit)         state_d = ST_WRITE_SEL;
        else if (expire) state_d = ST_IDLE;
      end
      ST_WRITE_SEL: begin
        op      = OP_SEL;
        state_d = ST_CK_ON;
      end
      ST_CK_ON: begin
        op      = OP_CK_ON;
        state_d = ST_WAIT_ON;
      end
      ST_WAIT_ON: begin
        if (hit)         state_d = ST_HANDOVER;
        else if (expire) state_d = ST_IDLE;
      end
      ST_HANDOVER: begin
        op      = OP_HANDOVER;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) phase_q <= req_phase;
      done_q <= (state_q == ST_HANDOVER);
      err_q  <= waiting && expire;
    end
  end

  assign op_done  = done_q;
  assign op_error = err_q;
endmodule

// File: rtl/tap_phase_sequencer_chk.sv
module tap_phase_sequencer_chk
  import tap_phase_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             ck_fb,
  input logic [CTL_W-1:0] ctl_word,
  input logic             op_done,
  input logic             op_error
);
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done && op_error)); // R10
  AST_READY_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done || op_error) |-> req_ready); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_error |=> !op_error); // R8
  AST_SEL_WHILE_CK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_word[POS_SEL_LSB +: 4]) |-> !ctl_word[POS_CK_EN]); // R3
  AST_CDR_AFTER_FB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_word[POS_CDR_EN]) |-> $past(ck_fb, 2)); // R6
  AST_CDR_EXT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_word[POS_CDR_EN] && ctl_word[POS_EXT_SEL])); // R2
  AST_ERR_NO_CDR: assert property (@(posedge clk) disable iff (!rst_n)
    op_error |-> !ctl_word[POS_CDR_EN]); // R8
endmodule

bind tap_phase_sequencer tap_phase_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ck_fb     (ck_fb),
  .ctl_word  (ctl_word),
  .op_done   (op_done),
  .op_error  (op_error)
);

// File: tb/tb_tap_phase_sequencer.sv
`timescale 1ns/1ps
module tb_tap_phase_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_phase = '0;
  logic        ck_fb;
  logic [31:0] ctl_word;
  logic        op_done, op_error;

  int checks = 0;
  int errors = 0;
  int fb_mode = 0;   // 0 follow, 1 pinned high, 2 pinned low
  int tick_div = 0;
  int cycles = 0;
  logic [2:0] fb_dly = '0;

  always #10 clk = ~clk;

  tap_phase_sequencer dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid),
    .req_ready(req_ready), .req_phase(req_phase), .ck_fb(ck_fb),
    .ctl_word(ctl_word), .op_done(op_done), .op_error(op_error)
  );

  always @(posedge clk) begin
    tick_div <= (tick_div == 9) ? 0 : tick_div + 1;
    us_tick  <= (tick_div == 9);
    fb_dly   <= {fb_dly[1:0], ctl_word[18]};
    cycles   <= cycles + 1;
  end
  assign ck_fb = (fb_mode == 0) ? fb_dly[2] : (fb_mode == 1);

  function automatic logic [3:0] gray_of(input logic [3:0] p);
    case (p)
      4'd0: return 4'd0;   4'd1: return 4'd1;   4'd2: return 4'd3;   4'd3: return 4'd2;
      4'd4: return 4'd6;   4'd5: return 4'd7;   4'd6: return 4'd5;   4'd7: return 4'd4;
      4'd8: return 4'd12;  4'd9: return 4'd13;  4'd10: return 4'd15; 4'd11: return 4'd14;
      4'd12: return 4'd10; 4'd13: return 4'd11; 4'd14: return 4'd9;  default: return 4'd8;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // bits {sel[3:0], ext, ck, cdr, line}
  function automatic logic [7:0] fields();
    return ctl_word[23:16];
  endfunction

  task automatic send(input logic [3:0] p);
    @(negedge clk);
    req_phase = p;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end(output int ticks, output bit got_done, output bit got_err);
    ticks = 0;
    for (int n = 0; n < 5000; n++) begin
      if (op_done || op_error) break;
      if (us_tick) ticks++;
      @(negedge clk);
    end
    got_done = op_done;
    got_err  = op_error;
  endtask

  task automatic t_reset();
    check("R1 ctl_word", ctl_word, 32'h0);
    check("R1 req_ready", {31'h0, req_ready}, 32'h1);
    check("R1 done/error", {30'h0, op_done, op_error}, 32'h0);
  endtask

  task automatic t_normal(input logic [3:0] p);
    int t; bit d, e;
    logic [3:0] old_sel;
    old_sel = ctl_word[23:20];
    send(p);
    check("R2 park fields", {24'h0, fields()}, {24'h0, old_sel, 4'b1001});
    wait_end(t, d, e);
    check("R6 done pulse", {30'h0, d, e}, 32'h2);
    check("R4 select gray", {28'h0, ctl_word[23:20]}, {28'h0, gray_of(p)});
    check("R6 final bits", {28'h0, ctl_word[19:16]}, 32'h7);
    check("R10 ready at done", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    check("R6 done one cycle", {31'h0, op_done}, 32'h0);
  endtask

  task automatic t_hold_select(input logic [3:0] p);
    int t; bit d, e;
    logic [3:0] old_sel;
    old_sel = ctl_word[23:20];
    fb_mode = 1;
    send(p);
    for (int k = 0; k < 250; k++) @(negedge clk);
    check("R3 select held while fb high", {28'h0, ctl_word[23:20]}, {28'h0, old_sel});
    check("R3 ck off while waiting", {31'h0, ctl_word[18]}, 32'h0);
    fb_mode = 0;
    wait_end(t, d, e);
    check("R5 completes after release", {30'h0, d, e}, 32'h2);
    check("R4 select after release", {28'h0, ctl_word[23:20]}, {28'h0, gray_of(p)});
  endtask

  task automatic t_timeout_off(input logic [3:0] p);
    int t; bit d, e;
    logic [3:0] old_sel;
    old_sel = ctl_word[23:20];
    fb_mode = 1;
    send(p);
    wait_end(t, d, e);
    check("R7 first-wait poll count", t, 50);
    check("R8 error not done", {30'h0, d, e}, 32'h1);
    check("R8 word frozen", {24'h0, fields()}, {24'h0, old_sel, 4'b1001});
    check("R8 ready after timeout", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    check("R8 error one cycle", {31'h0, op_error}, 32'h0);
    fb_mode = 0;
    for (int k = 0; k < 10; k++) @(negedge clk);
  endtask

  task automatic t_timeout_on(input logic [3:0] p);
    int t; bit d, e;
    fb_mode = 2;
    send(p);
    wait_end(t, d, e);
    check("R7 second-wait poll count", t, 51);
    check("R8 error on second wait", {30'h0, d, e}, 32'h1);
    check("R5 ck set, no cdr step", {24'h0, fields()}, {24'h0, gray_of(p), 4'b1101});
    fb_mode = 0;
    for (int k = 0; k < 10; k++) @(negedge clk);
  endtask

  task automatic t_busy_ignore(input logic [3:0] p, input logic [3:0] q);
    int t; bit d, e;
    send(p);
    @(negedge clk);
    check("R9 not ready while busy", {31'h0, req_ready}, 32'h0);
    req_phase = q;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_end(t, d, e);
    check("R9 done after ignored request", {30'h0, d, e}, 32'h2);
    check("R9 first phase kept", {28'h0, ctl_word[23:20]}, {28'h0, gray_of(p)});
    for (int k = 0; k < 3; k++) @(negedge clk);
    check("R9 no second operation", {31'h0, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_normal(4'd0);
    t_normal(4'd15);
    t_normal(4'd2);
    t_normal(4'd8);
    t_hold_select(4'd11);
    t_timeout_off(4'd6);
    t_normal(4'd13);
    t_timeout_on(4'd4);
    t_normal(4'd3);
    t_busy_ignore(4'd5, 4'd10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule